// File: doc/BRIEF.md
# Source-Synchronous Output Serializer

This block shifts a parallel conversion result out to a host over one, two or four data lanes. Alongside the data it drives a forwarded strobe that follows the launch clock, so the host can capture each bit against it. One 8-bit configuration word selects three things together: the launch clock, the lane count, and whether bits leave on rising edges only or on both edges.

Everything runs in the system clock domain. The launch clock is either an external serial clock, which is sampled and edge-detected, or an internal clock derived from the system clock. The internal clock has a half period of 1, 2 or 4 system cycles and is restarted at every frame start. The data word is captured when the start pulse arrives. When the frame is over, a one-cycle done flag marks its end.

Top module: `srcsync_ser`

## Requirements
- R1: After reset, all lanes and the strobe are low, the block is idle, and the stored configuration word is 0x03: external clock, single lane, single data rate.
- R2: Configuration bits [7:6] pick the launch clock. 00 is the external serial clock. 01, 10 and 11 are internal clocks with half periods of 1, 2 and 4 system cycles. An internal clock starts low at the frame start, and its first rising edge comes that many cycles after the start edge.
- R3: Configuration bits [3:2] pick the lanes. 10 is two lanes, 11 is four lanes, and 00 or 01 is one lane. Lanes that are not in use stay low. Data leaves MSB first, and lane 0 carries the most significant bit of each group.
- R4: When bit 4 is 0, new data is launched only on rising edges of the launch clock.
- R5: When bit 4 is 1, new data is launched on every launch-clock edge, beginning with the first rising edge. A falling edge that comes before the first rising edge of a frame has no effect.
- R6: The strobe goes high on each rising launch-clock edge and low on each falling edge, once the first rising edge of the frame has passed. With bit 4 set, it therefore toggles on every launch.
- R7: A frame launches ceil(WORD_W / lanes) groups. Bit positions below bit 0 of the word are sent as zeros.
- R8: At the first qualifying launch-clock edge after the last launch, the lanes and the strobe return low, busy drops, and done is high for exactly one cycle.
- R9: A configuration write is stored at any time but only takes effect at the next frame start. A write in the same cycle as a start applies to the following frame. A start pulse while a frame is running is ignored.
- R10: Outside a frame, every lane and the strobe are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Store cfg_i as the pending configuration |
| cfg_i | input | 8 | Configuration word (source [7:6], rate [4], lanes [3:2]) |
| start_i | input | 1 | Begin a frame and capture data_i |
| data_i | input | WORD_W | Parallel word to send |
| ext_sclk_i | input | 1 | External serial launch clock |
| lane_o | output | 4 | Data lanes, lane 0 in bit 0 |
| rvs_o | output | 1 | Forwarded strobe |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame flag |

## Verification
The hardest case to reach is an external-clock frame that starts while the external clock is high. There the falling edge comes first and must be ignored, even in double-rate mode. The bench drives a free-running external clock with a period of six system cycles and varies the idle gap before each start, so frames begin at every phase of that clock. A second hard case is a configuration write and a second start pulse during a busy frame. The bench issues both mid-frame and then starts a frame without writing, which shows that the held word is the one that takes effect.

// File: rtl/srcsync_pkg.sv
package srcsync_pkg;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'b00,
        SRC_INT  = 2'b01,
        SRC_DIV2 = 2'b10,
        SRC_DIV4 = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        LN_ONE  = 2'b00,
        LN_RSV  = 2'b01,
        LN_TWO  = 2'b10,
        LN_FOUR = 2'b11
    } lane_sel_e;

    typedef struct packed {
        clk_src_e  src;
        logic      spare;
        logic      ddr;
        lane_sel_e lanes;
        logic [1:0] mode_lo;
    } ser_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    localparam logic [7:0] CFG_RESET = 8'h03;
    localparam int         MAX_LANES = 4;

    function automatic int lane_count(lane_sel_e s);
        case (s)
            LN_TWO:  return 2;
            LN_FOUR: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int beat_count(int w, lane_sel_e s);
        return (w + lane_count(s) - 1) / lane_count(s);
    endfunction

    // last phase value of one internal half period
    function automatic logic [1:0] half_last(clk_src_e s);
        case (s)
            SRC_DIV2: return 2'd1;
            SRC_DIV4: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/srcsync_edge.sv
module srcsync_edge
    import srcsync_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     run,
    input  clk_src_e src,
    input  logic     ext_sclk_i,
    output edge_ev_t ev
);

    logic [1:0] phase_q;
    logic       lclk_q;
    logic       ext_q;
    logic       int_tick;

    assign int_tick = (phase_q == half_last(src));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 2'd0;
            lclk_q  <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            ext_q <= ext_sclk_i;
            if (restart) begin
                phase_q <= 2'd0;
                lclk_q  <= 1'b0;
            end else if (run && src != SRC_EXT) begin
                if (int_tick) begin
                    phase_q <= 2'd0;
                    lclk_q  <= ~lclk_q;
                end else begin
                    phase_q <= phase_q + 2'd1;
                end
            end
        end
    end

    always_comb begin
        ev = '0;
        if (run) begin
            if (src == SRC_EXT) begin
                ev.rise = ext_sclk_i & ~ext_q;
                ev.fall = ~ext_sclk_i & ext_q;
            end else if (int_tick) begin
                ev.rise = ~lclk_q;
                ev.fall = lclk_q;
            end
        end
    end

endmodule

// File: rtl/srcsync_lanes.sv
module srcsync_lanes
    import srcsync_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [WORD_W-1:0]    data_i,
    input  logic                 shift,
    input  lane_sel_e            sel,
    output logic [MAX_LANES-1:0] grp
);

    localparam int PW = ((WORD_W + MAX_LANES - 1) / MAX_LANES) * MAX_LANES;

    logic [PW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= PW'(data_i) << (PW - WORD_W);
        end else if (shift) begin
            sh_q <= sh_q << lane_count(sel);
        end
    end

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
        assign grp[l] = (l < lane_count(sel)) ? sh_q[PW-1-l] : 1'b0;
    end

endmodule

// File: rtl/srcsync_ser.sv
module srcsync_ser
    import srcsync_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we_i,
    input  logic [7:0]           cfg_i,
    input  logic                 start_i,
    input  logic [WORD_W-1:0]    data_i,
    input  logic                 ext_sclk_i,
    output logic [MAX_LANES-1:0] lane_o,
    output logic                 rvs_o,
    output logic                 busy_o,
    output logic                 done_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e                  st_q;
    ser_cfg_t             pend_q, act_q;
    logic [CNT_W-1:0]     cnt_q, beats;
    logic                 started_q;
    logic [MAX_LANES-1:0] lanes_q, grp;
    logic                 rvs_q, done_q;
    logic                 run, restart, launch, finish;
    edge_ev_t             ev;

    assign run     = (st_q == ST_RUN);
    assign restart = (st_q == ST_IDLE) && start_i;
    assign beats   = CNT_W'(beat_count(WORD_W, act_q.lanes));
    assign launch  = run && (cnt_q != beats) &&
                     (ev.rise || (ev.fall && started_q && act_q.ddr));
    assign finish  = run && (cnt_q == beats) &&
                     (ev.rise || (ev.fall && started_q));

    srcsync_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .run        (run),
        .src        (act_q.src),
        .ext_sclk_i (ext_sclk_i),
        .ev         (ev)
    );

    srcsync_lanes #(.WORD_W(WORD_W)) u_lanes (
        .clk    (clk),
        .rst    (rst),
        .load   (restart),
        .data_i (data_i),
        .shift  (launch),
        .sel    (act_q.lanes),
        .grp    (grp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pend_q    <= ser_cfg_t'(CFG_RESET);
            act_q     <= ser_cfg_t'(CFG_RESET);
            cnt_q     <= '0;
            started_q <= 1'b0;
            lanes_q   <= '0;
            rvs_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cfg_we_i) begin
                pend_q <= ser_cfg_t'(cfg_i);
            end
            if (st_q == ST_IDLE) begin
                lanes_q <= '0;
                rvs_q   <= 1'b0;
                if (start_i) begin
                    act_q     <= pend_q;
                    cnt_q     <= '0;
                    started_q <= 1'b0;
                    st_q      <= ST_RUN;
                end
            end else if (finish) begin
                st_q    <= ST_IDLE;
                lanes_q <= '0;
                rvs_q   <= 1'b0;
                done_q  <= 1'b1;
            end else if (launch) begin
                lanes_q <= grp;
                cnt_q   <= cnt_q + 1'b1;
                if (ev.rise) begin
                    rvs_q     <= 1'b1;
                    started_q <= 1'b1;
                end else begin
                    rvs_q <= 1'b0;
                end
            end else if (ev.fall && started_q) begin
                rvs_q <= 1'b0;
            end
        end
    end

    assign lane_o = lanes_q;
    assign rvs_o  = rvs_q;
    assign busy_o = run;
    assign done_o = done_q;

endmodule

// File: rtl/srcsync_ser_chk.sv
module srcsync_ser_chk
    import srcsync_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [MAX_LANES-1:0] lane_o,
    input logic                 rvs_o,
    input logic                 busy_o,
    input logic                 done_o,
    input ser_cfg_t             pend,
    input ser_cfg_t             act
);

    // R1: configuration word right after reset
    a_r1_reset_cfg: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend == ser_cfg_t'(CFG_RESET)));

    // R10: quiet outputs while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (lane_o == '0 && !rvs_o));

    // R8: done lasts one cycle and follows a busy frame
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_done_ends_frame: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9: active configuration does not move during a frame
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(act));

    // R3: unused lanes stay low
    a_r3_single_lane: assert property (@(posedge clk) disable iff (rst)
        (busy_o && act.lanes != LN_TWO && act.lanes != LN_FOUR) |-> (lane_o[3:1] == 3'b000));

    a_r3_dual_lane: assert property (@(posedge clk) disable iff (rst)
        (busy_o && act.lanes == LN_TWO) |-> (lane_o[3:2] == 2'b00));

    // R4: in single rate, data changes only together with a strobe rise
    a_r4_sdr_rise_only: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !act.ddr && lane_o != $past(lane_o)) |-> $rose(rvs_o));

endmodule

bind srcsync_ser srcsync_ser_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .lane_o (lane_o),
    .rvs_o  (rvs_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .pend   (pend_q),
    .act    (act_q)
);

// File: tb/srcsync_ser_test.sv
module srcsync_ser_test;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we_i = 1'b0;
    logic [7:0]   cfg_i = 8'h00;
    logic         start_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic         ext_sclk_i = 1'b0;
    logic [3:0]   lane_o;
    logic         rvs_o, busy_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int dut_dones = 0;
    int m_frames = 0;

    always #4 clk = ~clk;

    srcsync_ser #(.WORD_W(W)) uut (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_i(cfg_i),
        .start_i(start_i), .data_i(data_i), .ext_sclk_i(ext_sclk_i),
        .lane_o(lane_o), .rvs_o(rvs_o), .busy_o(busy_o), .done_o(done_o)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_pend, m_act;
    logic       m_busy, m_rvs, m_done, m_started, ext_prev;
    logic [3:0] m_lanes;
    logic [3:0] beats_q[$];
    int         tick, m_cnt;

    function automatic int lanes_of(logic [7:0] c);
        if (c[3:2] == 2'b10) return 2;
        if (c[3:2] == 2'b11) return 4;
        return 1;
    endfunction

    always @(posedge clk) begin
        logic ev, rise, xr, xf;
        int   hp, nl;
        xr = ext_sclk_i && !ext_prev;
        xf = !ext_sclk_i && ext_prev;
        if (rst) begin
            m_pend = 8'h03; m_act = 8'h03; m_busy = 0; m_rvs = 0; m_done = 0;
            m_lanes = 0; m_started = 0; ext_prev = 0; tick = 0; m_cnt = 0;
            beats_q.delete();
        end else begin
            m_done = 0;
            if (!m_busy) begin
                m_lanes = 0; m_rvs = 0;
                if (start_i) begin
                    m_act = m_pend; m_busy = 1; tick = 0; m_cnt = 0; m_started = 0;
                    m_frames++;
                    beats_q.delete();
                    nl = lanes_of(m_act);
                    for (int b = 0; b < (W + nl - 1) / nl; b++) begin
                        logic [3:0] v;
                        v = 0;
                        for (int l = 0; l < nl; l++) begin
                            int idx;
                            idx = W - 1 - (b * nl + l);
                            if (idx >= 0) v[l] = data_i[idx];
                        end
                        beats_q.push_back(v);
                    end
                end
            end else begin
                if (m_act[7:6] == 2'b00) begin
                    ev = xr || xf; rise = xr;
                end else begin
                    hp = 1 << (m_act[7:6] - 1);
                    tick++;
                    ev = (tick % hp) == 0;
                    rise = ((tick / hp) % 2) == 1;
                end
                if (ev && (rise || m_started)) begin
                    if (m_cnt == beats_q.size()) begin
                        m_busy = 0; m_lanes = 0; m_rvs = 0; m_done = 1;
                    end else if (rise) begin
                        m_lanes = beats_q[m_cnt]; m_cnt++; m_rvs = 1; m_started = 1;
                    end else begin
                        m_rvs = 0;
                        if (m_act[4]) begin
                            m_lanes = beats_q[m_cnt]; m_cnt++;
                        end
                    end
                end
            end
            if (cfg_we_i) m_pend = cfg_i;
        end
        ext_prev = ext_sclk_i;
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            n_cmp++;
            if (done_o) dut_dones++;
            if (lane_o !== m_lanes || rvs_o !== m_rvs || busy_o !== m_busy || done_o !== m_done) begin
                n_bad++;
                if (lane_o !== m_lanes)
                    $display("FAIL %s lanes: got %h expected %h (cycle %0d)",
                             m_busy ? "R2/R3/R4/R5/R7" : "R10", lane_o, m_lanes, cyc);
                if (rvs_o !== m_rvs)
                    $display("FAIL R6 strobe: got %b expected %b (cycle %0d)", rvs_o, m_rvs, cyc);
                if (busy_o !== m_busy)
                    $display("FAIL R8/R9 busy: got %b expected %b (cycle %0d)", busy_o, m_busy, cyc);
                if (done_o !== m_done)
                    $display("FAIL R8 done: got %b expected %b (cycle %0d)", done_o, m_done, cyc);
            end
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // free-running external serial clock, period six system cycles
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ext_sclk_i = ~ext_sclk_i;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
    endtask

    task automatic run_frame(input logic wr, input logic [7:0] c, input int gap);
        @(negedge clk);
        if (wr) begin cfg_we_i = 1; cfg_i = c; end
        @(negedge clk);
        cfg_we_i = 0;
        repeat (gap) @(negedge clk);
        data_i = W'($urandom);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        n_cmp++;
        if (lane_o !== 4'h0 || rvs_o !== 1'b0 || busy_o !== 1'b0 || done_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: got %h%b%b%b expected 0000", lane_o, rvs_o, busy_o, done_o);
        end
        // R1: first frame without any write uses the reset word
        run_frame(0, 8'h00, 1);
        // R2..R7: all source / lane / rate combinations, varied start phase
        for (int r = 0; r < 2; r++)
            for (int s = 0; s < 4; s++)
                for (int ln = 0; ln < 3; ln++) begin
                    logic [7:0] c;
                    c = {s[1:0], 1'b0, r[0], (ln == 0) ? 2'b00 : (ln == 1) ? 2'b10 : 2'b11, 2'b11};
                    run_frame(1, c, (s + ln + r) % 5);
                    run_frame(0, c, (s + 2 * ln + 3) % 7);
                end
        // R3: reserved lane code 01 behaves as a single lane
        run_frame(1, 8'h57, 2);
        // R9: write and start during a busy frame
        @(negedge clk);
        cfg_we_i = 1; cfg_i = 8'hCB;
        @(negedge clk);
        cfg_we_i = 0; data_i = W'($urandom); start_i = 1; cfg_we_i = 1; cfg_i = 8'h5F;
        @(negedge clk);
        start_i = 0; cfg_we_i = 0;
        repeat (10) @(negedge clk);
        cfg_we_i = 1; cfg_i = 8'h1B; start_i = 1;
        @(negedge clk);
        cfg_we_i = 0; start_i = 0;
        wait_idle();
        run_frame(0, 8'h00, 0);
        // R10: idle stretch with the external clock running
        repeat (20) @(negedge clk);
        // R8: one done per frame
        n_cmp++;
        if (dut_dones != m_frames) begin
            n_bad++;
            $display("FAIL R8 done count: got %0d expected %0d", dut_dones, m_frames);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule